// File: doc/BRIEF.md
# Dual-Direction Handshake Mailbox

This block carries short messages between a host processor and a signal processor through two 32-bit mailbox words, one for each direction. Each word is reached through two 16-bit registers, an upper half and a lower half. The top bit of each word is a message-pending flag, so no separate status register is needed. The sender writes the upper half first, which clears the flag. It then writes the lower half, which sets the flag. The receiver reads the upper half without side effects and reads the lower half last, and that read clears the flag.

All four registers sit on one 16-bit register bus with an address, a write strobe, a read strobe and registered read data. Only the low 8 bits of the address take part in decoding. With the default base of 0x10 the map is:

| Low address byte | Register |
| --- | --- |
| 0x10 | host-to-DSP word, upper half |
| 0x11 | host-to-DSP word, lower half |
| 0x12 | DSP-to-host word, upper half |
| 0x13 | DSP-to-host word, lower half |

Each word's flag is also driven on a dedicated pending output. The receiving side can use that output as a level interrupt or can poll it.

Top module: `duplex_mailbox`

## Requirements
- R1: While reset is asserted and after it is released, both words are zero, both pending outputs are low and read data is zero.
- R2: A write to an upper half stores write data bits 14:0 in word bits 30:16 and forces bit 31 to 0. Write data bit 15 is discarded, and word bits 15:0 are unchanged.
- R3: A write to a lower half stores write data in word bits 15:0, leaves bits 30:16 unchanged and forces bit 31 to 1.
- R4: A read of a lower half returns word bits 15:0 and clears bit 31 in the same access.
- R5: A read of an upper half returns word bits 31:16, with the pending flag in bit 15 of the read data, and leaves the word unchanged.
- R6: Only address bits 7:0 are decoded. The registers sit at base+0 to base+3 in the map order, with base 0x10 by default. An access to any other low byte changes no word, and a read of it returns zero.
- R7: When a read and a write strike the same register in one cycle, the read returns the value held before the cycle. The write's update is applied, so a lower-half read together with a write leaves the flag set.
- R8: Output dsp_msg_pending equals bit 31 of the host-to-DSP word, and cpu_msg_pending equals bit 31 of the DSP-to-host word, one cycle after the access that changed it.
- R9: Read data appears on the clock edge that samples the read strobe and holds its value until the next read.
- R10: An access to one word never changes the other word.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Register address; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| dsp_msg_pending | output | 1 | Flag of the host-to-DSP word |
| cpu_msg_pending | output | 1 | Flag of the DSP-to-host word |

## Verification
The directed sequences follow the intended handshake: an upper-half write, then a lower-half write, then reads of both halves. They also reverse that order, which shows that an upper-half write after the lower half withdraws the flag. Write data with bit 15 set tells apart a design that lets that bit reach the flag from one that discards it. Same-cycle read and write on both halves checks the priority rule and the pre-update read value. Aliased upper address bits and unmapped low bytes check the decode. A long mixed pattern interleaves both words so that any crosstalk between them, or a missed flag update, shows up against the reference model on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef logic [WORD_W-1:0] mbx_word_t;
  typedef logic [HALF_W-1:0] mbx_half_t;

  // per-mailbox access strobes produced by the decoder
  typedef struct packed {
    logic hi_wr;
    logic lo_wr;
    logic hi_rd;
    logic lo_rd;
  } mbx_acc_t;

  // upper-half write: flag dropped, message bits 30:16 replaced, low half kept
  function automatic mbx_word_t mbx_after_hi_write(mbx_word_t w, mbx_half_t d);
    mbx_word_t r;
    r = w;
    r[WORD_W-2:HALF_W] = d[HALF_W-2:0];
    r[WORD_W-1] = 1'b0;
    return r;
  endfunction

  // lower-half write: low half replaced, mid bits kept, flag raised
  function automatic mbx_word_t mbx_after_lo_write(mbx_word_t w, mbx_half_t d);
    mbx_word_t r;
    r = w;
    r[HALF_W-1:0] = d;
    r[WORD_W-1] = 1'b1;
    return r;
  endfunction

  // lower-half read: only the flag is consumed
  function automatic mbx_word_t mbx_after_lo_read(mbx_word_t w);
    mbx_word_t r;
    r = w;
    r[WORD_W-1] = 1'b0;
    return r;
  endfunction

  function automatic mbx_half_t mbx_pick_half(mbx_word_t w, logic sel_lo);
    return sel_lo ? w[HALF_W-1:0] : w[WORD_W-1:HALF_W];
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEC_W = 8,
  parameter logic [7:0] REG_BASE = 8'h10,
  parameter int NUM_BOX = 2,
  localparam int IDX_W = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  output mbx_acc_t [NUM_BOX-1:0] acc,
  output logic               hit,
  output logic [IDX_W-1:0]   box_idx,
  output logic               sel_lo
);

  localparam int NUM_REGS = 2 * NUM_BOX;

  logic [DEC_W-1:0] low_addr;
  logic [DEC_W-1:0] reg_ofs;
  logic             above_base;
  logic [NUM_BOX-1:0] box_touched;
  logic             unused_upper;

  assign low_addr     = addr[DEC_W-1:0];
  assign unused_upper = ^addr[ADDR_W-1:DEC_W];
  assign above_base   = (low_addr >= DEC_W'(REG_BASE));
  assign reg_ofs      = low_addr - DEC_W'(REG_BASE);
  assign hit          = above_base && (reg_ofs < DEC_W'(NUM_REGS));
  assign box_idx      = reg_ofs[IDX_W:1];
  assign sel_lo       = reg_ofs[0];

  for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
    logic mine;
    assign mine = hit && (reg_ofs[DEC_W-1:1] == (DEC_W-1)'(b));
    assign acc[b].hi_wr = mine && wr && !sel_lo;
    assign acc[b].lo_wr = mine && wr &&  sel_lo;
    assign acc[b].hi_rd = mine && rd && !sel_lo;
    assign acc[b].lo_rd = mine && rd &&  sel_lo;
    assign box_touched[b] = |acc[b];
  end

  // R6 / R10: one bus access reaches at most one mailbox
  always_comb begin
    p_one_box_r6: assert ($onehot0(box_touched) || $isunknown(box_touched))
      else $error("decode touched more than one mailbox");
  end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mbx_acc_t  acc,
  input  mbx_half_t wdata,
  output mbx_word_t word,
  output logic      pending
);

  // named events for the checks below
  logic ev_raise;
  logic ev_drop_wr;
  logic ev_consume;
  logic ev_quiet;

  assign ev_raise   = acc.lo_wr;
  assign ev_drop_wr = acc.hi_wr;
  assign ev_consume = acc.lo_rd && !acc.lo_wr;
  assign ev_quiet   = !(acc.lo_wr || acc.hi_wr || acc.lo_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (acc.lo_wr) begin
      word <= mbx_after_lo_write(word, wdata);
    end else if (acc.hi_wr) begin
      word <= mbx_after_hi_write(word, wdata);
    end else if (acc.lo_rd) begin
      word <= mbx_after_lo_read(word);
    end
  end

  assign pending = word[WORD_W-1];

  p_hi_write_drops_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop_wr |=> !pending);
  p_hi_write_keeps_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop_wr |=> word[HALF_W-1:0] == $past(word[HALF_W-1:0]));
  p_lo_write_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_raise |=> pending);
  p_lo_write_keeps_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_raise |=> word[WORD_W-2:HALF_W] == $past(word[WORD_W-2:HALF_W]));
  p_lo_read_consumes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_consume |=> !pending);
  p_quiet_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_quiet |=> $stable(word));

endmodule

// File: rtl/mbx_rdport.sv
module mbx_rdport
  import mbx_pkg::*;
#(
  parameter int NUM_BOX = 2,
  localparam int IDX_W = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd,
  input  logic                             hit,
  input  logic [IDX_W-1:0]                 box_idx,
  input  logic                             sel_lo,
  input  logic [NUM_BOX-1:0][WORD_W-1:0]   words,
  output mbx_half_t                        rdata
);

  mbx_half_t rd_next;

  always_comb begin
    rd_next = '0;
    if (hit) rd_next = mbx_pick_half(words[box_idx], sel_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= rd_next;
  end

  p_rdata_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  p_miss_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> rdata == '0);

endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [7:0] REG_BASE = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [15:0]       bus_rdata,
  output logic              dsp_msg_pending,
  output logic              cpu_msg_pending
);

  localparam int NUM_BOX = 2;
  localparam int IDX_W = $clog2(NUM_BOX);
  localparam int BOX_TO_DSP = 0;
  localparam int BOX_TO_CPU = 1;

  mbx_acc_t [NUM_BOX-1:0]         acc;
  logic [NUM_BOX-1:0][WORD_W-1:0] words;
  logic [NUM_BOX-1:0]             pend;
  logic                           hit;
  logic [IDX_W-1:0]               box_idx;
  logic                           sel_lo;

  mbx_decode #(
    .ADDR_W(ADDR_W), .DEC_W(8), .REG_BASE(REG_BASE), .NUM_BOX(NUM_BOX)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .acc(acc), .hit(hit), .box_idx(box_idx), .sel_lo(sel_lo)
  );

  for (genvar b = 0; b < NUM_BOX; b++) begin : g_slot
    mbx_word_t w;
    mbx_slot u_slot (
      .clk(clk), .rst_n(rst_n), .acc(acc[b]), .wdata(bus_wdata),
      .word(w), .pending(pend[b])
    );
    assign words[b] = w;
  end

  mbx_rdport #(.NUM_BOX(NUM_BOX)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .hit(hit), .box_idx(box_idx),
    .sel_lo(sel_lo), .words(words), .rdata(bus_rdata)
  );

  assign dsp_msg_pending = pend[BOX_TO_DSP];
  assign cpu_msg_pending = pend[BOX_TO_CPU];

  // port-level views of the lower-half registers, decoded independently
  logic to_dsp_lo_wr;
  logic to_cpu_lo_wr;
  assign to_dsp_lo_wr = bus_wr && (bus_addr[7:0] == REG_BASE + 8'd1);
  assign to_cpu_lo_wr = bus_wr && (bus_addr[7:0] == REG_BASE + 8'd3);

  p_dsp_pend_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    to_dsp_lo_wr |=> dsp_msg_pending);
  p_cpu_pend_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    to_cpu_lo_wr |=> cpu_msg_pending);
  p_write_beats_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (to_dsp_lo_wr && bus_rd) |=> dsp_msg_pending);
  p_other_box_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    to_dsp_lo_wr |=> $stable(cpu_msg_pending));

endmodule

// File: tb/sim_duplex_mailbox.sv
`timescale 1ns/1ps
module sim_duplex_mailbox;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic        bus_rd;
  logic [15:0] bus_rdata;
  logic        dsp_msg_pending;
  logic        cpu_msg_pending;

  always #2.5 clk = ~clk;

  duplex_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dsp_msg_pending(dsp_msg_pending), .cpu_msg_pending(cpu_msg_pending)
  );

  // reference state: two message words and the last read value
  bit [31:0] model_box [2];
  bit [15:0] model_rd;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    check({req, " rdata"}, bus_rdata, model_rd);
    check({req, " dsp_pend"}, {15'd0, dsp_msg_pending}, {15'd0, model_box[0][31]});
    check({req, " cpu_pend"}, {15'd0, cpu_msg_pending}, {15'd0, model_box[1][31]});
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic bus_cycle(string req, logic [15:0] a, logic w, logic [15:0] d, logic r);
    int ofs;
    int bx;
    bit is_lo;
    bit mapped;
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r;
    @(posedge clk);
    ofs = int'(a[7:0]) - 16;
    mapped = (ofs >= 0) && (ofs < 4);
    bx = ofs / 2;
    is_lo = (ofs % 2) == 1;
    if (r) begin
      if (!mapped) model_rd = 16'h0;
      else if (is_lo) model_rd = model_box[bx][15:0];
      else model_rd = model_box[bx][31:16];
    end
    if (mapped && w) begin
      if (is_lo) model_box[bx] = {1'b1, model_box[bx][30:16], d};
      else model_box[bx] = {1'b0, d[14:0], model_box[bx][15:0]};
    end else if (mapped && r && is_lo) begin
      model_box[bx][31] = 1'b0;
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    compare_all(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0;
    model_box[0] = '0; model_box[1] = '0; model_rd = '0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after reset");
    bus_cycle("R1 read 0x10", 16'h0010, 0, 0, 1);
    bus_cycle("R1 read 0x13", 16'h0013, 0, 0, 1);

    // upper-half write, bit 15 of data must not reach the flag
    bus_cycle("R2 hi write", 16'h0010, 1, 16'hFFFF, 0);
    bus_cycle("R2 hi readback", 16'h0010, 0, 0, 1);
    bus_cycle("R3 lo write", 16'h0011, 1, 16'h1234, 0);
    bus_cycle("R5 hi read flag", 16'h0010, 0, 0, 1);
    bus_cycle("R5 hi read no effect", 16'h0010, 0, 0, 1);
    bus_cycle("R4 lo read", 16'h0011, 0, 0, 1);
    bus_cycle("R4 hi after consume", 16'h0010, 0, 0, 1);

    // reverse order: flag withdrawn by the later upper write
    bus_cycle("R3 lo first", 16'h0011, 1, 16'hBEEF, 0);
    bus_cycle("R2 hi withdraws", 16'h0010, 1, 16'h0ACE, 0);
    bus_cycle("R2 low kept", 16'h0011, 0, 0, 1);

    // other direction, independence
    bus_cycle("R10 d2c hi", 16'h0012, 1, 16'h4321, 0);
    bus_cycle("R10 d2c lo", 16'h0013, 1, 16'h8765, 0);
    bus_cycle("R10 c2d hi untouched", 16'h0010, 0, 0, 1);
    bus_cycle("R8 d2c hi read", 16'h0012, 0, 0, 1);

    // R9: read data holds over idle cycles and writes
    bus_cycle("R9 idle", 16'h0000, 0, 0, 0);
    bus_cycle("R9 write no read", 16'h0011, 1, 16'h5555, 0);

    // R6: aliasing and unmapped addresses
    bus_cycle("R6 alias read", 16'hAB13, 0, 0, 1);
    bus_cycle("R6 unmapped write", 16'h0014, 1, 16'hFFFF, 0);
    bus_cycle("R6 unmapped read", 16'h000F, 0, 0, 1);
    bus_cycle("R6 unmapped write low", 16'h000F, 1, 16'h7777, 0);
    bus_cycle("R6 c2d lo intact", 16'h7F11, 0, 0, 1);
    bus_cycle("R6 d2c hi intact", 16'h0012, 0, 0, 1);

    // R7: read and write together
    bus_cycle("R7 lo rd+wr", 16'h0013, 1, 16'h0F0F, 1);
    bus_cycle("R7 lo after", 16'h0013, 0, 0, 1);
    bus_cycle("R7 set again", 16'h0011, 1, 16'h3333, 0);
    bus_cycle("R7 hi rd+wr", 16'h0010, 1, 16'h1111, 1);
    bus_cycle("R7 hi after", 16'h0010, 0, 0, 1);

    // mixed pattern over both words
    for (int i = 0; i < 48; i++) begin
      logic [15:0] a;
      logic [15:0] d;
      a = {i[7:0], 8'h10 + 8'((i * 7) % 4)};
      d = 16'(i * 16'h1357) ^ 16'hA5C3;
      bus_cycle("R10 mixed", a, (i % 3) != 0, d, (i % 2) == 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule